// File: doc/BRIEF.md
# Dual-Word Masked Interrupt Controller

This block collects up to 63 level-sensitive interrupt inputs and presents them to software as two 32-bit words for each function. Mask and pending state each occupy a high word and a low word on a small register bus. A source does not land on the bit whose index equals its number. A fixed, scrambled placement picks the word and the bit position for each source. The bus view is always translated through that placement, and the internal state stays in source order.

A pending bit is set whenever its input is high, whatever the mask holds. Software acknowledges a source by writing a one to that source's pending bit. While any pending source is also enabled, a single interrupt output is driven high. The vector register reports the lowest-numbered source that is both pending and enabled. Two priority-configuration words are kept for software as plain storage and come out of reset with a fixed default ordering pattern. Source number 0 is reserved, so a vector of zero means that nothing is waiting.

Top module: `irq_dualword_ctrl`

## Requirements
- R1: After synchronous reset, both mask words and both pending words read 0, the vector reads 0, `irq_out` is 0, and both priority words read 0x05309770.
- R2: Register addresses are 0 mask-high, 1 mask-low, 2 pending-high, 3 pending-low, 4 vector, 5 priority-high and 6 priority-low. Sources 1..15 sit in the low word at bit 16-s. Sources 16..31 sit in the high word at bit (34-s) mod 16, so 16 goes to bit 2, 18 to bit 0 and 19 to bit 15. Sources 32..47 sit in the low word at bit 63-s. Sources 48..63 sit in the high word at bit s-32.
- R3: A mask bit of 1 enables its source and a 0 blocks it. A blocked source still shows as pending but raises neither `irq_out` nor the vector. A mask bit changes only when its mask word is written.
- R4: Writing 1 to a pending bit clears it, provided its input is low. Writing 0 leaves the bit unchanged. Writing all ones to both pending words clears every source whose input is low.
- R5: A high input sets its pending bit at the next clock edge. If a clear-write and a high input reach the same bit at the same edge, the bit stays set.
- R6: The vector register holds the lowest-numbered source that is pending and enabled in bits 31:26, with bits 25:0 at zero. It reads 0 when no such source exists.
- R7: `irq_out` equals the OR of all pending-and-enabled bits as they stood one clock edge earlier.
- R8: Writes to the vector address and to address 7 change no state. Address 7 reads 0.
- R9: Source 0 has no input. Its pending and mask positions (low word, bit 0) always read 0.
- R10: Each priority word stores and returns all 32 bits written to it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| irq_src | input | 63 | Level inputs for sources 63..1 (bit index = source number) |
| reg_we | input | 1 | Register write strobe, taken at the rising edge |
| reg_addr | input | 3 | Register address for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| irq_out | output | 1 | Registered interrupt request |

## Verification
The assertions assume that reset is held high across at least one rising edge at start-up. They also assume that the write strobe, the address and the source inputs carry known values that are stable around each rising edge, since the level-wins and clear rules compare state against the inputs seen one edge before. The stimulus changes every input only on falling clock edges and samples the combinational read port a short delay after that edge. It keeps reset asserted for several cycles before any traffic.

// File: rtl/irqdw_pkg.sv
package irqdw_pkg;

   // register addresses; the map function below is tied to these word halves
   localparam int unsigned A_MASK_HI = 0;
   localparam int unsigned A_MASK_LO = 1;
   localparam int unsigned A_PEND_HI = 2;
   localparam int unsigned A_PEND_LO = 3;
   localparam int unsigned A_VECTOR  = 4;
   localparam int unsigned A_PRIO_HI = 5;
   localparam int unsigned A_PRIO_LO = 6;

   // sources are grouped in runs of sixteen that alternate between word halves
   function automatic logic src_on_high(input int unsigned s);
      return ((s / 16) % 2) == 1;
   endfunction

   // scrambled bit placement inside the selected word
   function automatic int unsigned src_bit(input int unsigned s);
      int unsigned grp;
      grp = s / 16;
      if (grp == 0)      return (16 - s) % 16;
      else if (grp == 1) return (34 - s) % 16;
      else if (grp == 2) return 63 - s;
      else               return s - 32;
   endfunction

endpackage

// File: rtl/irqdw_gather.sv
module irqdw_gather
   import irqdw_pkg::*;
#(
   parameter int unsigned NUM_SRC = 64,
   parameter int unsigned WORD_W  = 32
)(
   input  logic [NUM_SRC-1:1] per_src,
   output logic [WORD_W-1:0]  word_hi,
   output logic [WORD_W-1:0]  word_lo
);

   // source order -> bus word order
   always_comb begin
      word_hi = '0;
      word_lo = '0;
      for (int s = 1; s < NUM_SRC; s++) begin
         if (src_on_high(s)) word_hi[src_bit(s)] = per_src[s];
         else                word_lo[src_bit(s)] = per_src[s];
      end
   end

endmodule

// File: rtl/irqdw_bank.sv
module irqdw_bank #(
   parameter int unsigned NUM_SRC = 64
)(
   input  logic               clk,
   input  logic               rst,
   input  logic [NUM_SRC-1:1] src_lvl,
   input  logic [NUM_SRC-1:1] mask_we,
   input  logic [NUM_SRC-1:1] mask_d,
   input  logic [NUM_SRC-1:1] clr_req,
   output logic [NUM_SRC-1:1] mask_q,
   output logic [NUM_SRC-1:1] pend_q
);

   always_ff @(posedge clk) begin
      if (rst) begin
         mask_q <= '0;
         pend_q <= '0;
      end else begin
         mask_q <= (mask_q & ~mask_we) | (mask_d & mask_we);
         // a live level overrides an acknowledge in the same cycle
         pend_q <= (pend_q & ~clr_req) | src_lvl;
      end
   end

   a_r5_level_wins: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> ((pend_q & $past(src_lvl)) == $past(src_lvl)));

   a_r4_clear_takes: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> ((pend_q & $past(clr_req & ~src_lvl)) == '0));

   a_r3_mask_holds: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (((mask_q ^ $past(mask_q)) & ~$past(mask_we)) == '0));

endmodule

// File: rtl/irqdw_pick.sv
module irqdw_pick #(
   parameter int unsigned NUM_SRC  = 64,
   parameter bit          LOW_WINS = 1'b1,
   localparam int unsigned IDX_W   = $clog2(NUM_SRC)
)(
   input  logic [NUM_SRC-1:1] active,
   output logic [IDX_W-1:0]   winner
);

   if (LOW_WINS) begin : g_low_first
      always_comb begin
         winner = '0;
         for (int s = NUM_SRC - 1; s >= 1; s--)
            if (active[s]) winner = IDX_W'(s);
      end
   end else begin : g_high_first
      always_comb begin
         winner = '0;
         for (int s = 1; s < NUM_SRC; s++)
            if (active[s]) winner = IDX_W'(s);
      end
   end

   logic [NUM_SRC-1:0] act_full;
   logic [NUM_SRC-1:0] below_w;
   assign act_full = {active, 1'b0};
   assign below_w  = (NUM_SRC'(1) << winner) - NUM_SRC'(1);

   always_comb begin
      a_r6_empty_zero: assert ((winner == '0) == (active == '0));
      a_r6_pick_live: assert ((winner == '0) || act_full[winner]);
      if (LOW_WINS) begin
         a_r6_none_lower: assert ((act_full & below_w) == '0);
      end
   end

endmodule

// File: rtl/irq_dualword_ctrl.sv
module irq_dualword_ctrl
   import irqdw_pkg::*;
#(
   parameter int unsigned       NUM_SRC   = 64,
   parameter int unsigned       WORD_W    = 32,
   parameter int unsigned       ADDR_W    = 3,
   parameter logic [WORD_W-1:0] PRIO_INIT = 32'h0530_9770,
   parameter bit                LOW_WINS  = 1'b1
)(
   input  logic               clk,
   input  logic               rst,
   input  logic [NUM_SRC-1:1] irq_src,
   input  logic               reg_we,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic [WORD_W-1:0]  reg_wdata,
   output logic [WORD_W-1:0]  reg_rdata,
   output logic               irq_out
);

   localparam int unsigned IDX_W   = $clog2(NUM_SRC);
   localparam int unsigned VEC_LSB = WORD_W - IDX_W;

   if (NUM_SRC != 2 * WORD_W) begin : g_bad_count
      $error("source count must fill exactly two words");
   end
   if (WORD_W != 32) begin : g_bad_width
      $error("bit placement is defined for 32-bit words");
   end
   if (ADDR_W < 3) begin : g_bad_addr
      $error("address must reach seven registers");
   end

   // address decode
   logic we_mask_hi, we_mask_lo, we_pend_hi, we_pend_lo, we_prio_hi, we_prio_lo;
   assign we_mask_hi = reg_we && (reg_addr == ADDR_W'(A_MASK_HI));
   assign we_mask_lo = reg_we && (reg_addr == ADDR_W'(A_MASK_LO));
   assign we_pend_hi = reg_we && (reg_addr == ADDR_W'(A_PEND_HI));
   assign we_pend_lo = reg_we && (reg_addr == ADDR_W'(A_PEND_LO));
   assign we_prio_hi = reg_we && (reg_addr == ADDR_W'(A_PRIO_HI));
   assign we_prio_lo = reg_we && (reg_addr == ADDR_W'(A_PRIO_LO));

   // bus word order -> source order for writes
   logic [NUM_SRC-1:1] mask_we, mask_d, clr_req;
   for (genvar s = 1; s < NUM_SRC; s++) begin : g_scatter
      localparam bit          ON_HI = src_on_high(s);
      localparam int unsigned BPOS  = src_bit(s);
      logic wbit;
      assign wbit      = reg_wdata[BPOS];
      assign mask_d[s] = wbit;
      if (ON_HI) begin : g_hi
         assign mask_we[s] = we_mask_hi;
         assign clr_req[s] = we_pend_hi & wbit;
      end else begin : g_lo
         assign mask_we[s] = we_mask_lo;
         assign clr_req[s] = we_pend_lo & wbit;
      end
   end

   logic [NUM_SRC-1:1] mask_q, pend_q, active;

   irqdw_bank #(.NUM_SRC(NUM_SRC)) u_bank (
      .clk     (clk),
      .rst     (rst),
      .src_lvl (irq_src),
      .mask_we (mask_we),
      .mask_d  (mask_d),
      .clr_req (clr_req),
      .mask_q  (mask_q),
      .pend_q  (pend_q)
   );

   assign active = mask_q & pend_q;

   logic [IDX_W-1:0] vec_idx;
   irqdw_pick #(.NUM_SRC(NUM_SRC), .LOW_WINS(LOW_WINS)) u_pick (
      .active (active),
      .winner (vec_idx)
   );

   logic [WORD_W-1:0] mask_hi_w, mask_lo_w, pend_hi_w, pend_lo_w;
   irqdw_gather #(.NUM_SRC(NUM_SRC), .WORD_W(WORD_W)) u_gmask (
      .per_src (mask_q),
      .word_hi (mask_hi_w),
      .word_lo (mask_lo_w)
   );
   irqdw_gather #(.NUM_SRC(NUM_SRC), .WORD_W(WORD_W)) u_gpend (
      .per_src (pend_q),
      .word_hi (pend_hi_w),
      .word_lo (pend_lo_w)
   );

   logic [WORD_W-1:0] prio_hi, prio_lo;
   always_ff @(posedge clk) begin
      if (rst) begin
         prio_hi <= PRIO_INIT;
         prio_lo <= PRIO_INIT;
         irq_out <= 1'b0;
      end else begin
         if (we_prio_hi) prio_hi <= reg_wdata;
         if (we_prio_lo) prio_lo <= reg_wdata;
         irq_out <= |active;
      end
   end

   always_comb begin
      case (reg_addr)
         ADDR_W'(A_MASK_HI): reg_rdata = mask_hi_w;
         ADDR_W'(A_MASK_LO): reg_rdata = mask_lo_w;
         ADDR_W'(A_PEND_HI): reg_rdata = pend_hi_w;
         ADDR_W'(A_PEND_LO): reg_rdata = pend_lo_w;
         ADDR_W'(A_VECTOR):  reg_rdata = {vec_idx, {VEC_LSB{1'b0}}};
         ADDR_W'(A_PRIO_HI): reg_rdata = prio_hi;
         ADDR_W'(A_PRIO_LO): reg_rdata = prio_lo;
         default:            reg_rdata = '0;
      endcase
   end

   logic [NUM_SRC-1:0] mask_full;
   assign mask_full = {mask_q, 1'b0};

   a_r7_irq_follows: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (irq_out == $past(|(mask_q & pend_q))));

   a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> !irq_out);

   a_r3_vector_enabled: assert property (@(posedge clk) disable iff (rst)
      (vec_idx != '0) |-> mask_full[vec_idx]);

   a_r10_prio_hold: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(we_prio_hi)) |-> $stable(prio_hi));

endmodule

// File: tb/irq_dualword_ctrl_test.sv
`timescale 1ns/1ps
module irq_dualword_ctrl_test;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [63:1] irq_src = '0;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq_out;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   irq_dualword_ctrl uut (
      .clk(clk), .rst(rst), .irq_src(irq_src), .reg_we(reg_we),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .irq_out(irq_out)
   );

   localparam logic [2:0] MHI = 3'd0, MLO = 3'd1, PHI = 3'd2, PLO = 3'd3,
                          VEC = 3'd4, QHI = 3'd5, QLO = 3'd6, NONE = 3'd7;

   // placement from R2: returns 1 when the source sits in the high word
   function automatic bit exp_hi(input int s);
      return (s >= 16 && s <= 31) || (s >= 48);
   endfunction
   function automatic int exp_pos(input int s);
      if (s <= 15)      return (16 - s) % 16;
      else if (s <= 31) return (34 - s) % 16;
      else if (s <= 47) return 63 - s;
      else              return s - 32;
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic clear_all();
      irq_src = '0;
      wr(PHI, 32'hFFFF_FFFF);
      wr(PLO, 32'hFFFF_FFFF);
   endtask

   task automatic t_reset();
      logic [31:0] d;
      rd(MHI, d); chk("R1 mask hi", d, 0);
      rd(MLO, d); chk("R1 mask lo", d, 0);
      rd(PHI, d); chk("R1 pend hi", d, 0);
      rd(PLO, d); chk("R1 pend lo", d, 0);
      rd(VEC, d); chk("R1 vector", d, 0);
      rd(QHI, d); chk("R1 prio hi", d, 32'h0530_9770);
      rd(QLO, d); chk("R1 prio lo", d, 32'h0530_9770);
      chk("R1 irq", irq_out, 0);
   endtask

   task automatic t_map();
      logic [31:0] h, l;
      logic [63:0] e;
      for (int s = 1; s < 64; s++) begin
         @(negedge clk);
         irq_src = '0; irq_src[s] = 1'b1;
         @(negedge clk);
         irq_src = '0;
         rd(PHI, h); rd(PLO, l);
         e = '0;
         if (exp_hi(s)) e[32 + exp_pos(s)] = 1'b1; else e[exp_pos(s)] = 1'b1;
         chk($sformatf("R2 placement src %0d", s), {h, l}, e);
         wr(PHI, 32'hFFFF_FFFF);
         wr(PLO, 32'hFFFF_FFFF);
      end
      chk("R3 masked sources give no irq", irq_out, 0);
   endtask

   task automatic t_src0();
      logic [31:0] d;
      wr(MLO, 32'hFFFF_FFFF);
      rd(MLO, d); chk("R9 mask lo bit0 absent", d, 32'hFFFF_FFFE);
      wr(MHI, 32'hFFFF_FFFF);
      rd(MHI, d); chk("R3 mask hi readback", d, 32'hFFFF_FFFF);
      rd(PLO, d); chk("R9 pend lo bit0 zero", d, 0);
      wr(MLO, 0); wr(MHI, 0);
   endtask

   task automatic t_w1c();
      logic [31:0] d;
      @(negedge clk); irq_src[7] = 1'b1;
      @(negedge clk);
      rd(PLO, d); chk("R5 src7 sets lo bit9", d, 32'h0000_0200);
      wr(PLO, 32'h0000_0200);
      rd(PLO, d); chk("R5 level wins over clear", d, 32'h0000_0200);
      irq_src[7] = 1'b0;
      wr(PLO, 32'h0);
      rd(PLO, d); chk("R4 zero write keeps bit", d, 32'h0000_0200);
      wr(PLO, 32'h0000_0200);
      rd(PLO, d); chk("R4 one write clears bit", d, 0);
      @(negedge clk); irq_src[20] = 1'b1; irq_src[50] = 1'b1;
      @(negedge clk); irq_src = '0;
      rd(PHI, d); chk("R4 two high sources pending", d, 32'h0004_4000);
      clear_all();
      rd(PHI, d); chk("R4 all-ones clears hi", d, 0);
      rd(PLO, d); chk("R4 all-ones clears lo", d, 0);
   endtask

   task automatic t_pick();
      logic [31:0] d;
      @(negedge clk); irq_src[9] = 1'b1; irq_src[20] = 1'b1; irq_src[40] = 1'b1;
      @(negedge clk);
      rd(VEC, d); chk("R3 all masked vector zero", d, 0);
      chk("R3 all masked irq low", irq_out, 0);
      wr(MHI, 32'hFFFF_FFFF); wr(MLO, 32'hFFFF_FFFF);
      rd(VEC, d); chk("R6 lowest of 9/20/40", d, 32'h2400_0000);
      wr(MLO, ~(32'h1 << 7));
      rd(VEC, d); chk("R3 masking 9 exposes 20", d, 32'h5000_0000);
      wr(MHI, 32'h0);
      rd(VEC, d); chk("R3 masking 20 exposes 40", d, 32'hA000_0000);
      wr(MLO, 32'h0);
      rd(VEC, d); chk("R6 none enabled reads zero", d, 0);
      clear_all();
      wr(MHI, 32'hFFFF_FFFF); wr(MLO, 32'hFFFF_FFFF);
      @(negedge clk); irq_src[63] = 1'b1;
      @(negedge clk);
      rd(VEC, d); chk("R6 top source 63", d, 32'hFC00_0000);
      irq_src[2] = 1'b1;
      @(negedge clk);
      rd(VEC, d); chk("R6 source 2 beats 63", d, 32'h0800_0000);
      irq_src[1] = 1'b1;
      @(negedge clk);
      rd(VEC, d); chk("R6 source 1 beats 2", d, 32'h0400_0000);
      clear_all();
   endtask

   task automatic t_irq_timing();
      logic [31:0] d;
      @(negedge clk); irq_src[33] = 1'b1;
      @(negedge clk);
      chk("R7 irq waits one edge", irq_out, 0);
      rd(VEC, d); chk("R6 vector 33 immediate", d, 32'h8400_0000);
      @(negedge clk);
      chk("R7 irq raised", irq_out, 1);
      irq_src[33] = 1'b0;
      wr(PLO, 32'h4000_0000);
      rd(PLO, d); chk("R4 src33 cleared", d, 0);
      chk("R7 irq still high one edge", irq_out, 1);
      @(negedge clk);
      chk("R7 irq dropped", irq_out, 0);
   endtask

   task automatic t_readonly();
      logic [31:0] d;
      @(negedge clk); irq_src[3] = 1'b1;
      @(negedge clk);
      rd(VEC, d); chk("R6 vector 3", d, 32'h0C00_0000);
      wr(VEC, 32'hFFFF_FFFF);
      rd(VEC, d); chk("R8 vector write ignored", d, 32'h0C00_0000);
      rd(MLO, d); chk("R8 vector write leaves mask", d, 32'hFFFF_FFFE);
      wr(NONE, 32'h0000_1234);
      rd(NONE, d); chk("R8 address 7 reads zero", d, 0);
      rd(MHI, d); chk("R8 address 7 write leaves mask", d, 32'hFFFF_FFFF);
      rd(QHI, d); chk("R8 address 7 write leaves prio", d, 32'h0530_9770);
      clear_all();
   endtask

   task automatic t_prio();
      logic [31:0] d;
      wr(QHI, 32'h1234_5678);
      rd(QHI, d); chk("R10 prio hi stores", d, 32'h1234_5678);
      rd(QLO, d); chk("R10 prio lo untouched", d, 32'h0530_9770);
      wr(QLO, 32'hDEAD_BEEF);
      rd(QLO, d); chk("R10 prio lo stores", d, 32'hDEAD_BEEF);
      wr(QHI, 32'h0530_9770);
      rd(QHI, d); chk("R10 prio hi default value", d, 32'h0530_9770);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      t_reset();
      t_map();
      t_src0();
      t_w1c();
      t_pick();
      wr(MHI, 32'hFFFF_FFFF); wr(MLO, 32'hFFFF_FFFF);
      t_irq_timing();
      t_readonly();
      t_prio();
      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

endmodule